// File: doc/BRIEF.md
# DRAM Multipurpose Register Mode Tracker

This block sits on the memory side of a simplified DDR3 command bus. It decodes each command, keeps the contents of the third mode register, and enforces the rules for loading it. Two fields of that register matter: an enable bit, and a two-bit field that picks what reads return while the enable is set.

While the mode is off, a read produces an ordinary burst whose data comes from the array, which is outside this block. While it is on, reads are redirected to a fixed calibration pattern, and every other command is flagged. Loads of the register are checked against bank idleness, against reads still in flight, against reserved address bits, and against the minimum gaps that must follow any mode-register load. Every error is a one-cycle pulse in the cycle after the offending command. A command that raises any error other than the reserved-mode flag is discarded.

Top module: `mpr_mode_tracker`

## Requirements
- R1: After reset, and in every cycle where no burst beat or error pulse is due, all outputs are 0.
- R2: A load command (code 6) targets the tracked register only when bank address bits [1:0] are 3. In that case row address bit 2 becomes the enable and row address bits [1:0] become the select field. Loads with bank bits [1:0] of 0, 1 or 2 leave the register unchanged.
- R3: With the enable clear, an accepted read (code 2 or 3) raises data_valid_o for BURST consecutive cycles. The first of these cycles is RD_LAT cycles after the cycle in which the command is sampled. Throughout the burst, data_src_mpr_o is 0 and dq_o is 0.
- R4: With the enable set and the select field 00, every accepted read gives a burst with data_src_mpr_o = 1. Beat k drives all dq_o lanes to the value k mod 2, so the burst starts with all zeros. The register keeps this value across any number of reads.
- R5: With the enable set and a select field of 01, 10 or 11, an accepted read gives a burst with data_src_mpr_o = 1 and dq_o = 0. err_rsvd_mode_o pulses in the cycle after the read.
- R6: A load aimed at the tracked register with any of row address bits [14:3] set, or with bank bit 2 set, pulses err_rsvd_bit_o. The load is discarded.
- R7: A load aimed at the tracked register while any bank_idle_i bit is 0, or while an earlier read is still between issue and its last beat, pulses err_bad_load_o. The load is discarded.
- R8: After an accepted load to any mode register, another load less than T_MRD cycles later pulses err_timing_o and is discarded. Any other command except NOP (code 0) less than T_MOD cycles later does the same.
- R9: With the enable set, any command other than NOP, a read, or a load aimed at the tracked register pulses err_bad_cmd_o. This covers activate 1, write 4, precharge 5, refresh 7, power-down 8, self-refresh 9, calibration 10, and loads to the other registers. Such a command changes nothing.
- R10: With the enable clear, the select field has no effect: reads behave as in R3 and raise no reserved-mode flag.
- R11: Reset clears the register, so reads after reset behave as in R3 even if the mode was on before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 4 | Command code |
| ba_i | input | 3 | Bank address |
| addr_i | input | ROW_W | Row address, carrying the register field on loads |
| bank_idle_i | input | NBANK | Per-bank idle (precharged) flags |
| data_valid_o | output | 1 | Read burst beat strobe |
| data_src_mpr_o | output | 1 | 1 when the current beat comes from the pattern source |
| dq_o | output | DQ_W | Pattern data lanes |
| err_timing_o | output | 1 | Command issued inside a post-load gap |
| err_rsvd_bit_o | output | 1 | Load with reserved bits set |
| err_bad_load_o | output | 1 | Load while banks busy or a read in flight |
| err_bad_cmd_o | output | 1 | Non-read command while the mode is on |
| err_rsvd_mode_o | output | 1 | Read with a reserved select value |

## Verification
The bench builds the block with RD_LAT = 3, BURST = 8, T_MRD = 2, T_MOD = 6, four banks and eight data lanes. The short gaps let both timing windows be probed at their exact edges: a load one cycle after a load, and a read one cycle after a load. Each probe is then followed by a legal command within a few cycles. The short latency lets a load land inside a burst's last beats and still be checked, with many bursts fitting into the run.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'd0,
        CMD_ACT = 4'd1,
        CMD_RD  = 4'd2,
        CMD_RDA = 4'd3,
        CMD_WR  = 4'd4,
        CMD_PRE = 4'd5,
        CMD_MRS = 4'd6,
        CMD_REF = 4'd7,
        CMD_PDE = 4'd8,
        CMD_SRE = 4'd9,
        CMD_ZQC = 4'd10
    } cmd_e;

    typedef enum logic [1:0] {
        SRC_ARRAY   = 2'd0,
        SRC_PATTERN = 2'd1,
        SRC_ZERO    = 2'd2
    } src_e;

    typedef struct packed {
        logic timing;
        logic rsvd_bit;
        logic bad_load;
        logic bad_cmd;
        logic rsvd_mode;
    } err_t;

    typedef struct packed {
        logic valid;
        src_e src;
    } rd_tag_t;

    localparam logic [1:0] TRACKED_REG = 2'b11;
    localparam logic [1:0] SEL_PATTERN = 2'b00;

    function automatic logic is_read(input logic [3:0] c);
        return (c == CMD_RD) || (c == CMD_RDA);
    endfunction

endpackage

// File: rtl/mpr_cmd_check.sv
module mpr_cmd_check
    import mpr_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int ROW_W = 15,
    parameter int T_MRD = 4,
    parameter int T_MOD = 12,
    parameter int CNT_W = 4
) (
    input  logic [3:0]       cmd,
    input  logic [2:0]       ba,
    input  logic [ROW_W-1:0] addr,
    input  logic [NBANK-1:0] bank_idle,
    input  logic             rd_busy,
    input  logic             mode_en,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] gap,
    output err_t             err,
    output logic             acc_rd,
    output logic             acc_mrs,
    output logic             acc_tracked,
    output src_e             rd_src
);
    localparam logic [CNT_W-1:0] MRD_LIM = CNT_W'(T_MRD);
    localparam logic [CNT_W-1:0] MOD_LIM = CNT_W'(T_MOD);

    logic is_mrs, to_tracked, rd, ok;

    always_comb begin
        is_mrs     = (cmd == CMD_MRS);
        to_tracked = is_mrs && (ba[1:0] == TRACKED_REG);
        rd         = is_read(cmd);

        err.timing   = is_mrs ? (gap < MRD_LIM)
                              : ((cmd != CMD_NOP) && (gap < MOD_LIM));
        err.rsvd_bit = to_tracked && ((|addr[ROW_W-1:3]) || ba[2]);
        err.bad_load = to_tracked && (!(&bank_idle) || rd_busy);
        err.bad_cmd  = mode_en && (cmd != CMD_NOP) && !rd && !to_tracked;

        ok          = !(err.timing || err.rsvd_bit || err.bad_load || err.bad_cmd);
        acc_rd      = ok && rd;
        acc_mrs     = ok && is_mrs;
        acc_tracked = ok && to_tracked;

        if (!mode_en)                    rd_src = SRC_ARRAY;
        else if (mode_sel == SEL_PATTERN) rd_src = SRC_PATTERN;
        else                             rd_src = SRC_ZERO;

        err.rsvd_mode = acc_rd && mode_en && (mode_sel != SEL_PATTERN);
    end
endmodule

// File: rtl/mpr_gap_timer.sv
module mpr_gap_timer #(
    parameter int T_MOD = 12,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] gap
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(T_MOD);

    always_ff @(posedge clk) begin
        if (rst)             gap <= LIM;
        else if (restart)    gap <= CNT_W'(1);
        else if (gap != LIM) gap <= gap + CNT_W'(1);
    end
endmodule

// File: rtl/mpr_mode_reg.sv
module mpr_mode_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       en_d,
    input  logic [1:0] sel_d,
    output logic       mode_en,
    output logic [1:0] mode_sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_en  <= 1'b0;
            mode_sel <= 2'b00;
        end else if (load) begin
            mode_en  <= en_d;
            mode_sel <= sel_d;
        end
    end
endmodule

// File: rtl/mpr_burst_gen.sv
module mpr_burst_gen
    import mpr_pkg::*;
#(
    parameter int RD_LAT = 5,
    parameter int BURST  = 8,
    parameter int DQ_W   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch,
    input  src_e            launch_src,
    output logic            valid_o,
    output logic            src_mpr_o,
    output logic [DQ_W-1:0] dq_o,
    output logic            busy_o
);
    localparam int BEAT_W = (BURST > 2) ? $clog2(BURST) : 1;
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST - 1);

    rd_tag_t           pipe [RD_LAT];
    logic              active;
    src_e              cur_src;
    logic [BEAT_W-1:0] beat;

    for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= '{valid: launch, src: launch_src};
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cur_src <= SRC_ARRAY;
            beat    <= '0;
        end else if (pipe[RD_LAT-1].valid) begin
            active  <= 1'b1;
            cur_src <= pipe[RD_LAT-1].src;
            beat    <= '0;
        end else if (active) begin
            if (beat == LAST) active <= 1'b0;
            else              beat   <= beat + BEAT_W'(1);
        end
    end

    always_comb begin
        busy_o = active;
        for (int s = 0; s < RD_LAT; s++) busy_o = busy_o || pipe[s].valid;
    end

    assign valid_o   = active;
    assign src_mpr_o = active && (cur_src != SRC_ARRAY);
    assign dq_o      = {DQ_W{active && (cur_src == SRC_PATTERN) && beat[0]}};
endmodule

// File: rtl/mpr_mode_tracker.sv
module mpr_mode_tracker
    import mpr_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int ROW_W  = 15,
    parameter int DQ_W   = 16,
    parameter int RD_LAT = 5,
    parameter int BURST  = 8,
    parameter int T_MRD  = 4,
    parameter int T_MOD  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       cmd_i,
    input  logic [2:0]       ba_i,
    input  logic [ROW_W-1:0] addr_i,
    input  logic [NBANK-1:0] bank_idle_i,
    output logic             data_valid_o,
    output logic             data_src_mpr_o,
    output logic [DQ_W-1:0]  dq_o,
    output logic             err_timing_o,
    output logic             err_rsvd_bit_o,
    output logic             err_bad_load_o,
    output logic             err_bad_cmd_o,
    output logic             err_rsvd_mode_o
);
    localparam int CNT_W = $clog2(T_MOD + 1);

    logic             mode_en;
    logic [1:0]       mode_sel;
    logic [CNT_W-1:0] gap;
    logic             rd_busy, acc_rd, acc_mrs, acc_tracked;
    src_e             rd_src;
    err_t             err_now, err_q;

    mpr_cmd_check #(
        .NBANK(NBANK), .ROW_W(ROW_W), .T_MRD(T_MRD), .T_MOD(T_MOD), .CNT_W(CNT_W)
    ) u_check (
        .cmd(cmd_i), .ba(ba_i), .addr(addr_i), .bank_idle(bank_idle_i),
        .rd_busy(rd_busy), .mode_en(mode_en), .mode_sel(mode_sel), .gap(gap),
        .err(err_now), .acc_rd(acc_rd), .acc_mrs(acc_mrs),
        .acc_tracked(acc_tracked), .rd_src(rd_src)
    );

    mpr_gap_timer #(.T_MOD(T_MOD), .CNT_W(CNT_W)) u_gap (
        .clk(clk), .rst(rst), .restart(acc_mrs), .gap(gap)
    );

    mpr_mode_reg u_mode (
        .clk(clk), .rst(rst), .load(acc_tracked),
        .en_d(addr_i[2]), .sel_d(addr_i[1:0]),
        .mode_en(mode_en), .mode_sel(mode_sel)
    );

    mpr_burst_gen #(.RD_LAT(RD_LAT), .BURST(BURST), .DQ_W(DQ_W)) u_burst (
        .clk(clk), .rst(rst), .launch(acc_rd), .launch_src(rd_src),
        .valid_o(data_valid_o), .src_mpr_o(data_src_mpr_o), .dq_o(dq_o),
        .busy_o(rd_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= err_now;
    end

    assign err_timing_o    = err_q.timing;
    assign err_rsvd_bit_o  = err_q.rsvd_bit;
    assign err_bad_load_o  = err_q.bad_load;
    assign err_bad_cmd_o   = err_q.bad_cmd;
    assign err_rsvd_mode_o = err_q.rsvd_mode;
endmodule

// File: rtl/mpr_tracker_chk.sv
module mpr_tracker_chk #(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [3:0]      cmd_i,
    input logic            data_valid_o,
    input logic            data_src_mpr_o,
    input logic [DQ_W-1:0] dq_o,
    input logic            err_timing_o,
    input logic            err_rsvd_bit_o,
    input logic            err_bad_cmd_o,
    input logic            err_rsvd_mode_o,
    input logic            mode_en,
    input logic [1:0]      mode_sel
);
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !data_valid_o |-> (dq_o == '0 && !data_src_mpr_o));

    assert_array_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (data_valid_o && !data_src_mpr_o) |-> (dq_o == '0));

    assert_lanes_agree_R4: assert property (@(posedge clk) disable iff (rst)
        (dq_o == '0) || (dq_o == '1));

    assert_rsvd_mode_src_R5: assert property (@(posedge clk) disable iff (rst)
        err_rsvd_mode_o |-> ($past(mode_en) && $past(mode_sel) != 2'b00));

    assert_rsvd_bit_on_load_R6: assert property (@(posedge clk) disable iff (rst)
        err_rsvd_bit_o |-> ($past(cmd_i) == 4'd6));

    assert_timing_needs_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        err_timing_o |-> ($past(cmd_i) != 4'd0));

    assert_bad_cmd_in_mode_R9: assert property (@(posedge clk) disable iff (rst)
        err_bad_cmd_o |-> $past(mode_en));

    assert_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mode_en);
endmodule

bind mpr_mode_tracker mpr_tracker_chk #(.DQ_W(DQ_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_i(cmd_i),
    .data_valid_o(data_valid_o), .data_src_mpr_o(data_src_mpr_o), .dq_o(dq_o),
    .err_timing_o(err_timing_o), .err_rsvd_bit_o(err_rsvd_bit_o),
    .err_bad_cmd_o(err_bad_cmd_o), .err_rsvd_mode_o(err_rsvd_mode_o),
    .mode_en(mode_en), .mode_sel(mode_sel)
);

// File: tb/tb_mpr_mode_tracker.sv
module tb_mpr_mode_tracker;
    import mpr_pkg::*;

    localparam int NB = 4;
    localparam int RW = 15;
    localparam int DQ = 8;
    localparam int RL = 3;
    localparam int BL = 8;
    localparam int MRD = 2;
    localparam int MOD = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] cmd = 4'd0;
    logic [2:0] ba = 3'd0;
    logic [RW-1:0] addr = '0;
    logic [NB-1:0] idle = '1;
    logic dv, dsrc;
    logic [DQ-1:0] dq;
    logic e_tim, e_rb, e_bl, e_bc, e_rm;

    mpr_mode_tracker #(
        .NBANK(NB), .ROW_W(RW), .DQ_W(DQ), .RD_LAT(RL), .BURST(BL),
        .T_MRD(MRD), .T_MOD(MOD)
    ) dut (
        .clk(clk), .rst(rst), .cmd_i(cmd), .ba_i(ba), .addr_i(addr),
        .bank_idle_i(idle), .data_valid_o(dv), .data_src_mpr_o(dsrc), .dq_o(dq),
        .err_timing_o(e_tim), .err_rsvd_bit_o(e_rb), .err_bad_load_o(e_bl),
        .err_bad_cmd_o(e_bc), .err_rsvd_mode_o(e_rm)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            due;
        logic [4:0]    err;
        logic          v;
        logic          s;
        logic [DQ-1:0] d;
        string         req;
    } item_t;
    item_t q[$];

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_en = 0;
    logic [1:0] m_sel = 2'b00;
    int last_mrs = -1000;
    int busy_until = -1;

    task automatic push(input int due, input logic [4:0] err, input logic v,
                        input logic s, input logic [DQ-1:0] d, input string req);
        item_t it;
        it.due = due; it.err = err; it.v = v; it.s = s; it.d = d; it.req = req;
        q.push_back(it);
    endtask

    task automatic issue(input logic [3:0] c, input logic [2:0] b,
                         input logic [RW-1:0] a, input logic [NB-1:0] idl,
                         input string req);
        int e;
        bit is_mrs, to_trk, rd, early, rbit, bload, bcmd, ok, rmode;
        @(negedge clk);
        cmd = c; ba = b; addr = a; idle = idl;
        e = cyc + 1;
        is_mrs = (c == 4'd6);
        to_trk = is_mrs && (b[1:0] == 2'b11);
        rd     = (c == 4'd2) || (c == 4'd3);
        early  = is_mrs ? ((e - last_mrs) < MRD) : ((c != 4'd0) && ((e - last_mrs) < MOD));
        rbit   = to_trk && ((a[RW-1:3] != '0) || b[2]);
        bload  = to_trk && ((idl != '1) || (e <= busy_until));
        bcmd   = m_en && (c != 4'd0) && !rd && !to_trk;
        ok     = !(early || rbit || bload || bcmd);
        rmode  = ok && rd && m_en && (m_sel != 2'b00);
        if (early || rbit || bload || bcmd || rmode)
            push(e, {early, rbit, bload, bcmd, rmode}, 1'b0, 1'b0, '0, req);
        if (ok && rd) begin
            for (int k = 0; k < BL; k++) begin
                logic [DQ-1:0] dd;
                dd = (m_en && m_sel == 2'b00 && k[0]) ? '1 : '0;
                push(e + RL + k, 5'b0, 1'b1, m_en, dd, req);
            end
            busy_until = e + RL + BL;
        end
        if (ok && is_mrs) begin
            last_mrs = e;
            if (to_trk) begin
                m_en  = a[2];
                m_sel = a[1:0];
            end
        end
    endtask

    task automatic idle_n(input int n);
        repeat (n) begin
            @(negedge clk);
            cmd = 4'd0; ba = 3'd0; addr = '0; idle = '1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd = 4'd0; ba = 3'd0; addr = '0; idle = '1;
        for (int i = q.size() - 1; i >= 0; i--)
            if (q[i].due > cyc) q.delete(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_en = 0; m_sel = 2'b00; last_mrs = -1000; busy_until = -1;
    endtask

    // monitor: compare every cycle against the queue
    always @(negedge clk) begin
        if (cyc >= 2 && !done) begin
            logic [4:0] ee, ae;
            logic ev, es;
            logic [DQ-1:0] ed;
            string tag;
            ee = '0; ev = 0; es = 0; ed = '0; tag = "R1";
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    ee = ee | q[i].err;
                    ev = ev | q[i].v;
                    es = es | q[i].s;
                    ed = ed | q[i].d;
                    tag = q[i].req;
                    q.delete(i);
                end
            end
            ae = {e_tim, e_rb, e_bl, e_bc, e_rm};
            n_checks++;
            if (ae !== ee || dv !== ev || dsrc !== es || dq !== ed) begin
                n_fail++;
                $display("FAIL %s cycle %0d: err=%b v=%b s=%b dq=%h expected err=%b v=%b s=%b dq=%h",
                         tag, cyc, ae, dv, dsrc, dq, ee, ev, es, ed);
            end
        end
    end

    localparam int GAP = MOD + RL + BL + 2;
    localparam logic [RW-1:0] A_PAT  = 15'b000_0000_0000_0100;
    localparam logic [RW-1:0] A_SEL1 = 15'b000_0000_0000_0101;
    localparam logic [RW-1:0] A_SEL2 = 15'b000_0000_0000_0110;
    localparam logic [RW-1:0] A_OFF1 = 15'b000_0000_0000_0001;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle_n(4);                                   // R1 quiet after reset

        issue(4'd2, 3'd0, '0, '1, "R3");             // normal read
        idle_n(GAP);
        issue(4'd3, 3'd1, '0, '1, "R3");
        idle_n(GAP);

        issue(4'd6, 3'd0, A_PAT, '1, "R2");          // other registers: no mode change
        idle_n(MOD);
        issue(4'd6, 3'd1, A_PAT, '1, "R2");
        idle_n(MOD);
        issue(4'd6, 3'd2, A_PAT, '1, "R2");
        idle_n(MOD);
        issue(4'd2, 3'd0, '0, '1, "R2");
        idle_n(GAP);

        issue(4'd6, 3'd3, A_PAT, '1, "R2");          // enable pattern
        issue(4'd2, 3'd0, '0, '1, "R8");             // read one cycle after load
        idle_n(MOD);
        issue(4'd2, 3'd0, '0, '1, "R4");
        idle_n(GAP);
        issue(4'd3, 3'd0, '0, '1, "R4");
        idle_n(GAP);

        issue(4'd1, 3'd0, '0, '1, "R9");             // illegal in mode
        issue(4'd8, 3'd0, '0, '1, "R9");
        issue(4'd9, 3'd0, '0, '1, "R9");
        issue(4'd4, 3'd0, '0, '1, "R9");
        issue(4'd6, 3'd1, '0, '1, "R9");
        idle_n(2);
        issue(4'd2, 3'd0, '0, '1, "R9");             // still pattern
        idle_n(GAP);

        issue(4'd6, 3'd3, '0, 4'b1011, "R7");        // bank busy
        idle_n(2);
        issue(4'd2, 3'd0, '0, '1, "R7");
        idle_n(RL + BL - 1);
        issue(4'd6, 3'd3, '0, '1, "R7");             // load on last beat
        idle_n(GAP);

        issue(4'd6, 3'd3, A_PAT | 15'h0008, '1, "R6");
        idle_n(2);
        issue(4'd6, 3'd7, A_PAT, '1, "R6");
        idle_n(2);
        issue(4'd6, 3'd3, A_PAT | 15'h4000, '1, "R6");
        idle_n(2);
        issue(4'd2, 3'd0, '0, '1, "R6");             // pattern kept
        idle_n(GAP);

        issue(4'd6, 3'd3, A_SEL1, '1, "R5");
        issue(4'd6, 3'd3, A_SEL2, '1, "R8");         // load one cycle after load
        issue(4'd6, 3'd3, A_SEL2, '1, "R8");         // gap of MRD: accepted
        idle_n(MOD);
        issue(4'd2, 3'd0, '0, '1, "R5");
        idle_n(GAP);

        issue(4'd6, 3'd3, A_OFF1, '1, "R10");
        idle_n(MOD);
        issue(4'd2, 3'd0, '0, '1, "R10");
        idle_n(GAP);
        issue(4'd1, 3'd0, '0, '1, "R10");            // no longer flagged
        idle_n(GAP);

        issue(4'd6, 3'd3, A_PAT, '1, "R11");
        idle_n(MOD);
        issue(4'd2, 3'd0, '0, '1, "R11");
        idle_n(GAP);
        do_reset();
        idle_n(2);
        issue(4'd2, 3'd0, '0, '1, "R11");
        idle_n(GAP);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule